// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block holds the software-visible control state of one storage-style bus-master DMA channel. Through a small word-addressed register interface it keeps a command register with a start bit and a direction bit, a status register with active, error and interrupt bits, and a 32-bit base address for the descriptor table. It turns changes of the start bit into one-cycle start and halt controls for a separate descriptor walker. It gives that walker its direction and its current descriptor pointer, which is reloaded from the base address whenever a transfer starts.

The drive interrupt passes straight through to the host. A rising edge of the drive interrupt also latches the interrupt status bit, which software clears by writing one to it. The walker reports steps, completion and errors back through dedicated inputs. Walking the descriptors and the bus protocol are handled elsewhere.

Top module: `bm_dma_regs`

## Requirements
- R1: A write to word 0 with byte enable 0 set stores only bit 0 (start) and bit 3 (direction) of data byte 0. Byte 0 of word 0 reads back with all other bits zero, and `walk_dir` follows the stored bit 3.
- R2: A command write whose start bit equals the stored start bit produces no `walk_kick` or `walk_halt` pulse and leaves the active bit unchanged. The direction bit is still updated.
- R3: A command write that changes start from 0 to 1 loads `walk_ptr` with the base address held before that write. It sets the active bit (status bit 0, read at word 0 bit 16) and raises `walk_kick` for exactly one cycle after the write edge.
- R4: A command write that changes start from 1 to 0 clears the active bit and raises `walk_halt` for exactly one cycle.
- R5: Writes to word 1 replace only the byte lanes whose `wr_be` bit is set. Base address bits [1:0] always read as zero.
- R6: `host_irq` equals `drv_irq` in the same cycle at both levels. A rising edge of `drv_irq` sets the interrupt bit (status bit 2, word 0 bit 18). A level that stays high does not set the bit again after it has been cleared.
- R7: In a status write (word 0, byte enable 2), a one in bit 1 (error, word bit 17) or bit 2 (interrupt, word bit 18) clears that bit. Zeros have no effect, and the active bit cannot be written.
- R8: `walk_done` clears the active bit, and `walk_err` sets the error bit.
- R9: Each `walk_step` while the channel is active advances `walk_ptr` by DESC_BYTES (8).
- R10: When a set event (`walk_err` or a rising `drv_irq`) and a write-one-to-clear of the same bit fall in one cycle, the bit ends set.
- R11: Reset clears command, status, base address and pointer, and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_word | input | 2 | Word index of write (0 control/status, 1 base) |
| wr_be | input | 4 | Byte-lane enables |
| wr_data | input | 32 | Write data |
| rd_word | input | 2 | Word index of read (0 control/status, 1 base, 2 pointer) |
| rd_data | output | 32 | Read data, combinational |
| walk_kick | output | 1 | One-cycle start pulse to the walker |
| walk_halt | output | 1 | One-cycle stop pulse to the walker |
| walk_ptr | output | 32 | Current descriptor pointer |
| walk_dir | output | 1 | Transfer direction |
| walk_step | input | 1 | Walker moved to the next descriptor |
| walk_done | input | 1 | Walker finished the transfer |
| walk_err | input | 1 | Walker hit an error |
| drv_irq | input | 1 | Interrupt from the drive |
| host_irq | output | 1 | Interrupt to the host |

## Verification
The interrupt latch and the error bit can each see a set event and a software write-one-to-clear in the same cycle. The bench provokes this by raising `drv_irq` and asserting `walk_err` on the very edge where a status write clears both bits. It judges the result by reading the status byte afterwards and expecting both bits still set. It also clears the interrupt bit while the drive line stays high, so that a level-sensitive latch cannot pass as an edge-triggered one.

// File: rtl/bm_dma_regs.sv
module bm_dma_regs #(
  parameter int AW = 32,
  parameter int DESC_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_word,
  input  logic [AW/8-1:0] wr_be,
  input  logic [AW-1:0] wr_data,
  input  logic [1:0]    rd_word,
  output logic [AW-1:0] rd_data,
  output logic          walk_kick,
  output logic          walk_halt,
  output logic [AW-1:0] walk_ptr,
  output logic          walk_dir,
  input  logic          walk_step,
  input  logic          walk_done,
  input  logic          walk_err,
  input  logic          drv_irq,
  output logic          host_irq
);
  localparam int NB = AW / 8;

  logic          start_q, dir_q, act_q, err_q, int_q, irq_q;
  logic [AW-1:0] base_q;

  wire ctl_wr  = wr_en && (wr_word == 2'd0);
  wire cmd_hit = ctl_wr && wr_be[0];
  wire st_hit  = ctl_wr && wr_be[2];
  wire go_rise = cmd_hit && wr_data[0] && !start_q;
  wire go_fall = cmd_hit && !wr_data[0] && start_q;
  wire irq_rise = drv_irq && !irq_q;

  assign host_irq = drv_irq;
  assign walk_dir = dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      dir_q   <= 1'b0;
    end else if (cmd_hit) begin
      start_q <= wr_data[0];
      dir_q   <= wr_data[3];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      walk_kick <= 1'b0;
      walk_halt <= 1'b0;
    end else begin
      walk_kick <= go_rise && !act_q;
      walk_halt <= go_fall;
      if (go_rise)
        act_q <= 1'b1;
      else if (go_fall || walk_done)
        act_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      walk_ptr <= '0;
    else if (go_rise)
      walk_ptr <= base_q;
    else if (walk_step && act_q)
      walk_ptr <= walk_ptr + AW'(DESC_BYTES);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      int_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= drv_irq;
      if (walk_err)
        err_q <= 1'b1;
      else if (st_hit && wr_data[17])
        err_q <= 1'b0;
      if (irq_rise)
        int_q <= 1'b1;
      else if (st_hit && wr_data[18])
        int_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        base_q[i*8 +: 8] <= 8'h00;
      else if (wr_en && (wr_word == 2'd1) && wr_be[i])
        base_q[i*8 +: 8] <= (i == 0) ? (wr_data[7:0] & 8'hFC) : wr_data[i*8 +: 8];
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_word)
      2'd0: begin
        rd_data[0]  = start_q;
        rd_data[3]  = dir_q;
        rd_data[16] = act_q;
        rd_data[17] = err_q;
        rd_data[18] = int_q;
      end
      2'd1: rd_data = base_q;
      2'd2: rd_data = walk_ptr;
      default: rd_data = '0;
    endcase
  end

  a_r3_kick_means_active: assert property (@(posedge clk) disable iff (!rst_n)
    walk_kick |-> act_q);
  a_r4_halt_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
    walk_halt |-> !act_q);
  a_r5_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    base_q[1:0] == 2'b00);
  a_r6_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_irq) |=> int_q);
  a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done && !wr_en) |=> !act_q);
  a_r4_no_double_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(walk_kick && walk_halt));
endmodule

// File: tb/bm_dma_regs_test.sv
module bm_dma_regs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_word = '0;
  logic [3:0] wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [1:0] rd_word = '0;
  logic [31:0] rd_data;
  logic walk_kick, walk_halt, walk_dir, host_irq;
  logic [31:0] walk_ptr;
  logic walk_step = 1'b0, walk_done = 1'b0, walk_err = 1'b0, drv_irq = 1'b0;

  int total = 0;
  int bad = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  bm_dma_regs uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word), .wr_be(wr_be),
    .wr_data(wr_data), .rd_word(rd_word), .rd_data(rd_data),
    .walk_kick(walk_kick), .walk_halt(walk_halt), .walk_ptr(walk_ptr),
    .walk_dir(walk_dir), .walk_step(walk_step), .walk_done(walk_done),
    .walk_err(walk_err), .drv_irq(drv_irq), .host_irq(host_irq)
  );

  localparam logic [67:0] VEC [7] = '{
    {4'hF, 32'h12345677, 32'h12345674},
    {4'h1, 32'h000000FF, 32'h123456FC},
    {4'h2, 32'h0000AB00, 32'h1234ABFC},
    {4'hC, 32'hCAFE0000, 32'hCAFEABFC},
    {4'h4, 32'h00990000, 32'hCA99ABFC},
    {4'h0, 32'hFFFFFFFF, 32'hCA99ABFC},
    {4'h8, 32'h01000000, 32'h0199ABFC}
  };

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", rq, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] w, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_word = w; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic rd(input logic [1:0] w, output logic [31:0] d);
    rd_word = w;
    #1;
    d = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, v); chk("R11 reset ctl", v, 32'h0);
    rd(2'd1, v); chk("R11 reset base", v, 32'h0);
    chk("R11 reset ptr", walk_ptr, 32'h0);
    chk("R11 reset pulses", {30'b0, walk_kick, walk_halt}, 32'h0);

    for (int i = 0; i < 7; i++) begin
      wr(2'd1, VEC[i][67:64], VEC[i][63:32]);
      rd(2'd1, v);
      chk("R5 base lanes", v, VEC[i][31:0]);
    end

    wr(2'd0, 4'h1, 32'h000000FF);
    chk("R3 kick pulse", {31'b0, walk_kick}, 32'h1);
    chk("R3 ptr reload", walk_ptr, 32'h0199ABFC);
    rd(2'd0, v); chk("R1 R3 cmd mask and active", v, 32'h00010009);
    chk("R1 dir out", {31'b0, walk_dir}, 32'h1);
    @(negedge clk);
    chk("R3 kick one cycle", {31'b0, walk_kick}, 32'h0);

    wr(2'd0, 4'h1, 32'h00000001);
    chk("R2 no pulse", {30'b0, walk_kick, walk_halt}, 32'h0);
    rd(2'd0, v); chk("R2 dir updated, active kept", v, 32'h00010001);

    @(negedge clk); walk_step = 1'b1;
    @(negedge clk); @(negedge clk); walk_step = 1'b0;
    chk("R9 pointer step", walk_ptr, 32'h0199AC0C);

    wr(2'd0, 4'h1, 32'h00000000);
    chk("R4 halt pulse", {31'b0, walk_halt}, 32'h1);
    rd(2'd0, v); chk("R4 active cleared", v, 32'h0);
    wr(2'd0, 4'h1, 32'h00000000);
    chk("R2 no halt when unchanged", {31'b0, walk_halt}, 32'h0);

    wr(2'd0, 4'h1, 32'h00000001);
    chk("R3 ptr reload again", walk_ptr, 32'h0199ABFC);
    @(negedge clk); walk_done = 1'b1;
    @(negedge clk); walk_done = 1'b0;
    rd(2'd0, v); chk("R8 done clears active", v, 32'h00000001);
    wr(2'd0, 4'h1, 32'h00000001);
    chk("R2 same start no kick", {31'b0, walk_kick}, 32'h0);

    @(negedge clk); walk_err = 1'b1;
    @(negedge clk); walk_err = 1'b0;
    rd(2'd0, v); chk("R8 error set", v, 32'h00020001);
    wr(2'd0, 4'h4, 32'h00000000);
    rd(2'd0, v); chk("R7 zero write no effect", v, 32'h00020001);
    wr(2'd0, 4'h4, 32'h00070000);
    rd(2'd0, v); chk("R7 w1c error, active not written", v, 32'h00000001);

    @(negedge clk); drv_irq = 1'b1; #1;
    chk("R6 host follows high", {31'b0, host_irq}, 32'h1);
    @(negedge clk);
    rd(2'd0, v); chk("R6 interrupt latched", v, 32'h00040001);
    wr(2'd0, 4'h4, 32'h00040000);
    @(negedge clk);
    rd(2'd0, v); chk("R6 R7 cleared, no retrigger on level", v, 32'h00000001);
    drv_irq = 1'b0; #1;
    chk("R6 host follows low", {31'b0, host_irq}, 32'h0);

    @(negedge clk);
    drv_irq = 1'b1; walk_err = 1'b1;
    wr_en = 1'b1; wr_word = 2'd0; wr_be = 4'h4; wr_data = 32'h00060000;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0; walk_err = 1'b0;
    rd(2'd0, v); chk("R10 set beats clear", v, 32'h00060001);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, v); chk("R11 reset ctl again", v, 32'h0);
    rd(2'd1, v); chk("R11 reset base again", v, 32'h0);
    chk("R11 reset ptr again", walk_ptr, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule